// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides, during instruction decode of a five-stage 32-bit pipeline, whether fetch continues sequentially or is redirected. It looks at the instruction held in the fetch/decode register. For the two conditional branch kinds it compares two source operands. For branches it forms the target from the incremented PC and the immediate, and for jumps it forms the target from the 26-bit index field. When the flow is redirected it raises a fetch-flush line, so the wrongly fetched instruction becomes a nop. A taken branch or a jump therefore costs one bubble.

Operands for the compare come from the register-file read ports. The one exception is the EX/MEM register: when it holds an ALU result destined for a compare source, that result is forwarded instead. Results further down the pipe need no path, because the register file writes before it reads. When a source is still being produced, the block raises a stall: either the instruction in EX writes it, or a load in EX/MEM writes it. During a stall the surrounding pipeline holds the PC and the fetch/decode register and injects a bubble into ID/EX. The block is purely combinational.

Top module: `bru_id_resolve`

## Requirements
- R1: Opcode is bits 31:26, rs is bits 25:21 and rt is bits 20:16. Opcode 6'b000100 is taken when the two compare operands are equal. Opcode 6'b000101 is taken when they differ.
- R2: The branch target equals the incremented PC plus the sign-extended bits 15:0 shifted left by two.
- R3: Opcode 6'b000010 is an unconditional jump. Its target is incremented-PC bits 31:28 joined with bits 25:0 and two zero bits.
- R4: `pc_sel` uses 0 for sequential, 1 for the branch target and 2 for the jump target. `fetch_flush` is high exactly when `pc_sel` is nonzero.
- R5: Any other opcode gives `pc_sel` 0 with no flush, no stall and no forwarding.
- R6: For a branch, the EX/MEM ALU result replaces compare operand A (or B) when all of these hold: the EX/MEM write enable is set, the EX/MEM load flag is clear, and its destination is nonzero and equals rs (or rt). `fwd_a` and `fwd_b` show the choice. A zero destination or a cleared enable gives no forwarding.
- R7: A branch stalls when the ID/EX write enable is set and the ID/EX destination is nonzero and equals rs or rt.
- R8: A branch stalls when EX/MEM is a load with its write enable set and a nonzero destination equal to rs or rt.
- R9: While `stall` is high, `pc_sel` is 0 and `fetch_flush` is low.
- R10: A jump never stalls, whatever the hazard inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_instr | input | 32 | Instruction in decode |
| ifid_pc4 | input | 32 | Incremented PC of that instruction |
| rf_data_a | input | 32 | Register-file read of rs |
| rf_data_b | input | 32 | Register-file read of rt |
| idex_dst | input | 5 | Destination of the instruction in EX |
| idex_wen | input | 1 | Register write enable of the instruction in EX |
| exmem_dst | input | 5 | Destination held in EX/MEM |
| exmem_wen | input | 1 | Register write enable held in EX/MEM |
| exmem_load | input | 1 | EX/MEM holds a load |
| exmem_result | input | 32 | ALU result held in EX/MEM |
| pc_sel | output | 2 | Next-PC select (0 seq, 1 branch, 2 jump) |
| branch_target | output | 32 | Computed branch target |
| jump_target | output | 32 | Computed jump target |
| fetch_flush | output | 1 | Zero the fetch/decode instruction |
| stall | output | 1 | Hold PC and fetch/decode, bubble ID/EX |
| fwd_a | output | 1 | Operand A taken from EX/MEM |
| fwd_b | output | 1 | Operand B taken from EX/MEM |

## Verification
The assertions run on every evaluation and cover the structural rules: flush agrees with a non-sequential select, a stall excludes both flush and redirect, forwarding and stalling occur only for branch opcodes, and jumps never stall. Whether a branch is actually taken or not, the target arithmetic (including negative offsets), and each forwarding or stall condition with its zero-register and write-enable exclusions are shown only by the bench's scenarios. The bench compares those against values it computes from the requirements.

// File: rtl/bru_pkg.sv
// Shared encodings for the decode-stage branch resolver.
// Assumes the classic 32-bit fixed-format encoding with a 6-bit major opcode.
package bru_pkg;
    localparam int OPC_W = 6;
    localparam logic [OPC_W-1:0] OPC_JMP = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BNE = 6'b000101;

    typedef enum logic [1:0] {
        PCS_SEQ = 2'd0,
        PCS_BR  = 2'd1,
        PCS_JMP = 2'd2
    } pcsel_e;
endpackage

// File: rtl/bru_decode.sv
// Splits the decode-stage instruction into the fields the resolver needs.
// Assumes opcode in the top six bits, rs/rt next, then a 16-bit immediate.
module bru_decode
    import bru_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_AW = 5
) (
    input  logic [XLEN-1:0]   instr,
    output logic              is_beq,
    output logic              is_bne,
    output logic              is_jmp,
    output logic [REG_AW-1:0] rs,
    output logic [REG_AW-1:0] rt,
    output logic [15:0]       imm,
    output logic [25:0]       jidx
);
    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_AW;
    localparam int RT_LSB  = RS_LSB - REG_AW;

    logic [OPC_W-1:0] opc;

    // Field extraction and opcode classification
    always_comb begin
        opc    = instr[XLEN-1 -: OPC_W];
        rs     = instr[RS_LSB +: REG_AW];
        rt     = instr[RT_LSB +: REG_AW];
        imm    = instr[15:0];
        jidx   = instr[25:0];
        is_beq = (opc == OPC_BEQ);
        is_bne = (opc == OPC_BNE);
        is_jmp = (opc == OPC_JMP);
    end
endmodule

// File: rtl/bru_operand_fwd.sv
// Picks one compare operand: register-file data, or the EX/MEM ALU result
// when that stage writes the same nonzero register and is not a load.
// Results older than EX/MEM rely on write-before-read in the register file.
module bru_operand_fwd #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic              is_branch,
    input  logic [REG_AW-1:0] src,
    input  logic [XLEN-1:0]   rf_data,
    input  logic [REG_AW-1:0] exmem_dst,
    input  logic              exmem_wen,
    input  logic              exmem_load,
    input  logic [XLEN-1:0]   exmem_result,
    output logic [XLEN-1:0]   opnd,
    output logic              fwd
);
    // Forward decision and operand mux
    always_comb begin
        fwd  = is_branch && exmem_wen && !exmem_load &&
               (exmem_dst != '0) && (exmem_dst == src);
        opnd = fwd ? exmem_result : rf_data;
    end
endmodule

// File: rtl/bru_hazard.sv
// Detects compare sources that are not yet available to a decode-stage branch:
// an ALU or load result still in EX, or load data still in EX/MEM.
module bru_hazard #(
    parameter int REG_AW = 5
) (
    input  logic              is_branch,
    input  logic [REG_AW-1:0] rs,
    input  logic [REG_AW-1:0] rt,
    input  logic [REG_AW-1:0] idex_dst,
    input  logic              idex_wen,
    input  logic [REG_AW-1:0] exmem_dst,
    input  logic              exmem_wen,
    input  logic              exmem_load,
    output logic              stall
);
    logic ex_hit;
    logic mem_hit;

    // Match either source against the two producing stages
    always_comb begin
        ex_hit  = idex_wen && (idex_dst != '0) &&
                  ((idex_dst == rs) || (idex_dst == rt));
        mem_hit = exmem_wen && exmem_load && (exmem_dst != '0) &&
                  ((exmem_dst == rs) || (exmem_dst == rt));
        stall   = is_branch && (ex_hit || mem_hit);
    end
endmodule

// File: rtl/bru_targets.sv
// Computes both redirect addresses in parallel with the register read.
module bru_targets #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc4,
    input  logic [15:0]     imm,
    input  logic [25:0]     jidx,
    output logic [XLEN-1:0] br_tgt,
    output logic [XLEN-1:0] j_tgt
);
    localparam int SEXT_W = XLEN - 18;

    // Branch: sign-extended word offset; jump: region bits plus word index
    always_comb begin
        br_tgt = pc4 + {{SEXT_W{imm[15]}}, imm, 2'b00};
        j_tgt  = {pc4[XLEN-1 -: 4], jidx, 2'b00};
    end
endmodule

// File: rtl/bru_id_resolve.sv
// Top of the decode-stage branch resolver. Combinational: selects the next PC,
// flushes the fetch/decode register on a redirect, and stalls a branch whose
// compare sources are still in flight. Jumps never stall.
module bru_id_resolve
    import bru_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic [XLEN-1:0]   ifid_instr,
    input  logic [XLEN-1:0]   ifid_pc4,
    input  logic [XLEN-1:0]   rf_data_a,
    input  logic [XLEN-1:0]   rf_data_b,
    input  logic [REG_AW-1:0] idex_dst,
    input  logic              idex_wen,
    input  logic [REG_AW-1:0] exmem_dst,
    input  logic              exmem_wen,
    input  logic              exmem_load,
    input  logic [XLEN-1:0]   exmem_result,
    output logic [1:0]        pc_sel,
    output logic [XLEN-1:0]   branch_target,
    output logic [XLEN-1:0]   jump_target,
    output logic              fetch_flush,
    output logic              stall,
    output logic              fwd_a,
    output logic              fwd_b
);
    localparam int NSRC = 2;

    logic              is_beq, is_bne, is_jmp, is_branch;
    logic [REG_AW-1:0] rs, rt;
    logic [15:0]       imm;
    logic [25:0]       jidx;
    logic [NSRC-1:0][REG_AW-1:0] src_idx;
    logic [NSRC-1:0][XLEN-1:0]   src_rf;
    logic [NSRC-1:0][XLEN-1:0]   src_val;
    logic [NSRC-1:0]             src_fwd;
    logic              taken;
    pcsel_e            sel;

    bru_decode #(.XLEN(XLEN), .REG_AW(REG_AW)) u_dec (
        .instr(ifid_instr), .is_beq(is_beq), .is_bne(is_bne), .is_jmp(is_jmp),
        .rs(rs), .rt(rt), .imm(imm), .jidx(jidx)
    );

    // Group the two compare sources for the replicated forwarding muxes
    always_comb begin
        is_branch  = is_beq || is_bne;
        src_idx[0] = rs;
        src_idx[1] = rt;
        src_rf[0]  = rf_data_a;
        src_rf[1]  = rf_data_b;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        bru_operand_fwd #(.XLEN(XLEN), .REG_AW(REG_AW)) u_fwd (
            .is_branch(is_branch), .src(src_idx[g]), .rf_data(src_rf[g]),
            .exmem_dst(exmem_dst), .exmem_wen(exmem_wen),
            .exmem_load(exmem_load), .exmem_result(exmem_result),
            .opnd(src_val[g]), .fwd(src_fwd[g])
        );
    end

    bru_hazard #(.REG_AW(REG_AW)) u_haz (
        .is_branch(is_branch), .rs(rs), .rt(rt),
        .idex_dst(idex_dst), .idex_wen(idex_wen),
        .exmem_dst(exmem_dst), .exmem_wen(exmem_wen),
        .exmem_load(exmem_load), .stall(stall)
    );

    bru_targets #(.XLEN(XLEN)) u_tgt (
        .pc4(ifid_pc4), .imm(imm), .jidx(jidx),
        .br_tgt(branch_target), .j_tgt(jump_target)
    );

    // Branch outcome and next-PC select; a stalled branch stays sequential
    always_comb begin
        taken = (is_beq && (src_val[0] == src_val[1])) ||
                (is_bne && (src_val[0] != src_val[1]));
        if (is_jmp)
            sel = PCS_JMP;
        else if (taken && !stall)
            sel = PCS_BR;
        else
            sel = PCS_SEQ;
        pc_sel      = sel;
        fetch_flush = (sel != PCS_SEQ);
        fwd_a       = src_fwd[0];
        fwd_b       = src_fwd[1];
    end
endmodule

// File: rtl/bru_id_resolve_chk.sv
// Checker for the decode-stage branch resolver; observes ports only.
module bru_id_resolve_chk (
    input logic [31:0] ifid_instr,
    input logic [1:0]  pc_sel,
    input logic        fetch_flush,
    input logic        stall,
    input logic        fwd_a,
    input logic        fwd_b
);
    logic [5:0] opc;
    logic       br_op;
    logic       jmp_op;

    always_comb begin
        opc    = ifid_instr[31:26];
        br_op  = (opc == 6'b000100) || (opc == 6'b000101);
        jmp_op = (opc == 6'b000010);
        // R4
        flush_sel_chk: assert (fetch_flush == (pc_sel != 2'd0));
        // R9
        stall_quiet_chk: assert (!stall || (pc_sel == 2'd0 && !fetch_flush));
        // R6
        fwd_branch_only_chk: assert (!(fwd_a || fwd_b) || br_op);
        // R7
        stall_branch_only_chk: assert (!stall || br_op);
        // R10
        jump_no_stall_chk: assert (!jmp_op || (!stall && pc_sel == 2'd2));
        // R5
        other_seq_chk: assert (br_op || jmp_op || pc_sel == 2'd0);
    end
endmodule

bind bru_id_resolve bru_id_resolve_chk u_chk (
    .ifid_instr(ifid_instr), .pc_sel(pc_sel), .fetch_flush(fetch_flush),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
);

// File: tb/bru_id_resolve_bench.sv
module bru_id_resolve_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] ifid_instr, ifid_pc4, rf_data_a, rf_data_b, exmem_result;
    logic [4:0]  idex_dst, exmem_dst;
    logic        idex_wen, exmem_wen, exmem_load;
    logic [1:0]  pc_sel;
    logic [31:0] branch_target, jump_target;
    logic        fetch_flush, stall, fwd_a, fwd_b;

    bru_id_resolve u_bru_id_resolve (.*);

    typedef struct {
        logic [1:0]  sel;
        logic        flush, stl, fa, fb;
        logic [31:0] bt, jt;
        string       req;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Driver: apply one decode-stage situation and push its expectation
    task automatic drive(input string req, input logic [31:0] ins, input logic [31:0] pc4,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] idd, input logic idw,
                         input logic [4:0] exd, input logic exw, input logic exl,
                         input logic [31:0] res);
        exp_t e;
        logic [5:0] opc;
        logic [4:0] rs, rt;
        logic br, fa, fb, st;
        logic [31:0] va, vb;
        @(posedge clk);
        #1;
        ifid_instr = ins; ifid_pc4 = pc4; rf_data_a = a; rf_data_b = b;
        idex_dst = idd; idex_wen = idw; exmem_dst = exd; exmem_wen = exw;
        exmem_load = exl; exmem_result = res;
        opc = ins[31:26]; rs = ins[25:21]; rt = ins[20:16];
        br = (opc == 6'b000100) || (opc == 6'b000101);
        fa = br && exw && !exl && exd != 0 && exd == rs;
        fb = br && exw && !exl && exd != 0 && exd == rt;
        va = fa ? res : a;
        vb = fb ? res : b;
        st = br && ((idw && idd != 0 && (idd == rs || idd == rt)) ||
                    (exw && exl && exd != 0 && (exd == rs || exd == rt)));
        e.req = req; e.fa = fa; e.fb = fb; e.stl = st;
        e.bt = pc4 + {{14{ins[15]}}, ins[15:0], 2'b00};
        e.jt = {pc4[31:28], ins[25:0], 2'b00};
        if (opc == 6'b000010) e.sel = 2'd2;
        else if (!st && ((opc == 6'b000100 && va == vb) || (opc == 6'b000101 && va != vb)))
            e.sel = 2'd1;
        else e.sel = 2'd0;
        e.flush = (e.sel != 2'd0);
        sb.push_back(e);
    endtask

    // Monitor: compare outputs mid-cycle against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.req, "pc_sel", {30'd0, pc_sel}, {30'd0, e.sel});
            chk(e.req, "fetch_flush", {31'd0, fetch_flush}, {31'd0, e.flush});
            chk(e.req, "stall", {31'd0, stall}, {31'd0, e.stl});
            chk(e.req, "fwd_a", {31'd0, fwd_a}, {31'd0, e.fa});
            chk(e.req, "fwd_b", {31'd0, fwd_b}, {31'd0, e.fb});
            chk(e.req, "branch_target", branch_target, e.bt);
            chk(e.req, "jump_target", jump_target, e.jt);
        end
    end

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] s,
                                          input logic [4:0] t, input logic [15:0] im);
        return {op, s, t, im};
    endfunction

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ifid_instr = 0; ifid_pc4 = 0; rf_data_a = 0; rf_data_b = 0;
        idex_dst = 0; idex_wen = 0; exmem_dst = 0; exmem_wen = 0;
        exmem_load = 0; exmem_result = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R5 reset/idle state: all-zero instruction is not a control transfer
        drive("R5", 32'h0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R5 arithmetic opcode with hazards that must be ignored
        drive("R5", itype(6'b001000, 5'd3, 5'd4, 16'h0010), 32'h100, 1, 2, 5'd3, 1, 5'd4, 1, 1, 9);
        // R1 R2 beq equal, positive offset
        drive("R1 R2", itype(6'b000100, 5'd1, 5'd2, 16'h0008), 32'h0000_1004, 7, 7, 0, 0, 0, 0, 0, 0);
        // R1 beq unequal
        drive("R1", itype(6'b000100, 5'd1, 5'd2, 16'h0008), 32'h0000_1004, 7, 8, 0, 0, 0, 0, 0, 0);
        // R1 bne unequal taken, R2 negative offset
        drive("R1 R2", itype(6'b000101, 5'd1, 5'd2, 16'hFFFC), 32'h0000_2000, 3, 4, 0, 0, 0, 0, 0, 0);
        // R1 bne equal not taken
        drive("R1", itype(6'b000101, 5'd1, 5'd2, 16'hFFFC), 32'h0000_2000, 4, 4, 0, 0, 0, 0, 0, 0);
        // R3 R4 jump
        drive("R3 R4", {6'b000010, 26'h2AB_CDEF}, 32'hA000_0040, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10 jump with both hazards present
        drive("R10", {6'b000010, 5'd6, 21'h12345}, 32'h4000_0000, 0, 0, 5'd6, 1, 5'd6, 1, 1, 0);
        // R6 forward rs: stale rf differs, forwarded value matches rt
        drive("R6", itype(6'b000100, 5'd5, 5'd6, 16'h0004), 32'h300, 1, 55, 0, 0, 5'd5, 1, 0, 55);
        // R6 forward rt on bne
        drive("R6", itype(6'b000101, 5'd5, 5'd6, 16'h0004), 32'h300, 20, 20, 0, 0, 5'd6, 1, 0, 21);
        // R6 zero destination: no forwarding
        drive("R6", itype(6'b000100, 5'd0, 5'd6, 16'h0004), 32'h300, 0, 0, 0, 0, 5'd0, 1, 0, 99);
        // R6 write enable low: no forwarding
        drive("R6", itype(6'b000100, 5'd5, 5'd6, 16'h0004), 32'h300, 8, 8, 0, 0, 5'd5, 0, 0, 99);
        // R7 R9 EX stage writes rt: stall, no redirect
        drive("R7 R9", itype(6'b000100, 5'd5, 5'd6, 16'h0004), 32'h300, 8, 8, 5'd6, 1, 0, 0, 0, 0);
        // R7 zero destination in EX: no stall
        drive("R7", itype(6'b000100, 5'd0, 5'd6, 16'h0004), 32'h300, 8, 8, 5'd0, 1, 0, 0, 0, 0);
        // R8 R9 load in EX/MEM writes rs: stall, no forwarding
        drive("R8 R9", itype(6'b000101, 5'd9, 5'd6, 16'h0004), 32'h300, 1, 2, 0, 0, 5'd9, 1, 1, 1);
        // R8 load with write enable low: no stall
        drive("R8", itype(6'b000101, 5'd9, 5'd6, 16'h0004), 32'h300, 1, 2, 0, 0, 5'd9, 0, 1, 1);
        wait (sb.size() == 0);
        @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule